// File: doc/BRIEF.md
# Per-Pin GPIO Debounce Filter

This block cleans up the input levels of a 32-pin general-purpose I/O bank before they reach the readback and interrupt logic. Every pin gets a small two-sample filter. A pin whose filter is switched off passes its raw level straight through. A pin whose filter is on shows a level only after that level has been seen at two sampling points in a row.

One sampling source is shared by all pins. A programmable divider on the bus clock produces a sampling tick every 2 × (divider + 1) clock cycles. Each pin decides for itself whether it samples on that tick or on every clock edge.

Several clients can ask for different debounce periods while there is only one divider. For that case the divider write has a keep-maximum mode: the held value only grows, so the longest period asked for is the one in force. A plain load mode replaces the value outright. Every write restarts the divider count from zero. The raw inputs are expected to be synchronized to `clk` already.

Top module: `pin_deglitch_bank`

## Requirements
- R1: Asynchronous active-low reset clears every filter so that a filtered pin reads 0. It also clears the divider value and its count to zero, so the first tick is active at the second clock edge after reset is released, and one falls on every second edge after that.
- R2: A pin whose `filt_en` bit is 0 drives `pin_out` from `pin_raw` in the same cycle, with no register on the path.
- R3: A filtered pin with `slow_sel` = 0 samples on every clock edge. A new input level that is present at two consecutive rising edges appears on `pin_out` right after the second of them. A level that is present at only one edge is ignored.
- R4: With divider value N, sampling ticks fall exactly 2 × (N + 1) clock edges apart. After a restart at edge W, the first tick is at edge W + 2 × (N + 1).
- R5: A filtered pin with `slow_sel` = 1 samples only at tick edges. Its output takes a new level at the second of two consecutive ticks that both saw that level. A level seen at only one tick is ignored.
- R6: A divider write with `div_keep_max` = 0 loads `div_val` as it is, including a value smaller than the one held.
- R7: A divider write with `div_keep_max` = 1 stores the larger of `div_val` and the held value.
- R8: Every divider write restarts the count from zero, even if the value does not change. When a write lands on a tick edge, that tick still samples the slow pins, and the next tick follows 2 × (N + 1) edges later.
- R9: A pin's filter keeps tracking its input while `filt_en` is 0. When the filter is switched on, the output shows the level the filter already holds, not the raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the undivided sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_raw | input | 32 | Synchronized raw pin levels |
| filt_en | input | 32 | Per-pin filter enable (1 = filtered output) |
| slow_sel | input | 32 | Per-pin sampling choice (1 = divided tick, 0 = every clock) |
| div_val | input | 24 | Divider value offered with a write |
| div_wr | input | 1 | One-cycle divider write strobe |
| div_keep_max | input | 1 | Write mode: 1 keeps the larger value, 0 loads |
| pin_out | output | 32 | Debounced pin levels |

## Verification
Two events can fall on the same clock edge: a divider write, which restarts the count, and a sampling tick that is due. The bench sets up a known tick schedule and then places a write exactly on a tick edge, with a slow pin's new level arriving at that same edge. The result is judged from when that pin switches. The pin must switch one full period after the collision. That happens only if the colliding tick sampled the pin and the counter restarted. A lost tick would delay the switch by a further period.

// File: rtl/deb_pkg.sv
package deb_pkg;

    // How a divider write combines with the value already held.
    typedef enum logic {
        WR_LOAD = 1'b0,  // replace the held value
        WR_MAX  = 1'b1   // keep whichever is larger
    } wr_mode_e;

endpackage

// File: rtl/deb_tick_gen.sv
module deb_tick_gen
    import deb_pkg::*;
#(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  wr_mode_e         wr_mode,
    input  logic [DIV_W-1:0] wr_val,
    output logic             tick
);
    // The count runs 0 .. 2N+1, which gives a period of 2(N+1) edges.
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = {st_q.div, 1'b1};
        tick  = (st_q.cnt == limit);

        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        // A write always restarts the count; the tick already due this
        // cycle is still delivered.
        if (wr_stb) begin
            st_d.cnt = '0;
            if (wr_mode == WR_LOAD || wr_val > st_q.div) begin
                st_d.div = wr_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/deb_pin_filter.sv
module deb_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic sample_en,
    input  logic filt_on,
    output logic settled,
    output logic level
);
    typedef struct packed {
        logic smp;  // level seen at the last sampling point
        logic flt;  // accepted level
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_en) begin
            st_d.smp = raw;
            if (raw == st_q.smp) begin
                st_d.flt = raw;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign settled = st_q.flt;
    assign level   = filt_on ? st_q.flt : raw;

endmodule

// File: rtl/pin_deglitch_bank.sv
module pin_deglitch_bank
    import deb_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int DIV_W    = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] filt_en,
    input  logic [NUM_PINS-1:0] slow_sel,
    input  logic [DIV_W-1:0]    div_val,
    input  logic                div_wr,
    input  logic                div_keep_max,
    output logic [NUM_PINS-1:0] pin_out
);
    logic                slow_tick;
    logic [NUM_PINS-1:0] flt_vec;
    wr_mode_e            wr_mode;

    assign wr_mode = div_keep_max ? WR_MAX : WR_LOAD;

    deb_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (div_wr),
        .wr_mode (wr_mode),
        .wr_val  (div_val),
        .tick    (slow_tick)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic samp;
        assign samp = slow_sel[i] ? slow_tick : 1'b1;

        deb_pin_filter u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (pin_raw[i]),
            .sample_en (samp),
            .filt_on   (filt_en[i]),
            .settled   (flt_vec[i]),
            .level     (pin_out[i])
        );
    end

endmodule

// File: rtl/deb_checker.sv
module deb_checker #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_raw,
    input logic [NUM_PINS-1:0] slow_sel,
    input logic                div_wr,
    input logic                slow_tick,
    input logic [NUM_PINS-1:0] flt_vec
);
    // R1: filters hold 0 while reset is active
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (flt_vec == '0);
        end
    end

    // R4: the shortest period is two edges, so ticks never come back to back
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> !slow_tick);

    // R8: a write restarts the count, so no tick in the following cycle
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !slow_tick);

    // R3: a fast pin changes only to a level seen at its last two edges
    a_r3_fast_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|((flt_vec ^ $past(flt_vec)) & ~$past(slow_sel))) |->
        ((((flt_vec ^ $past(pin_raw)) | (flt_vec ^ $past(pin_raw, 2)))
          & (flt_vec ^ $past(flt_vec)) & ~$past(slow_sel)) == '0));

    // R5: a slow pin changes only at a tick edge
    a_r5_slow_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (|((flt_vec ^ $past(flt_vec)) & $past(slow_sel))) |-> $past(slow_tick));

endmodule

bind pin_deglitch_bank deb_checker #(
    .NUM_PINS (NUM_PINS)
) u_deb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_raw   (pin_raw),
    .slow_sel  (slow_sel),
    .div_wr    (div_wr),
    .slow_tick (slow_tick),
    .flt_vec   (flt_vec)
);

// File: tb/pin_deglitch_bank_test.sv
module pin_deglitch_bank_test;
    localparam int NP = 32;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_raw;
    logic [NP-1:0] filt_en;
    logic [NP-1:0] slow_sel;
    logic [DW-1:0] div_val;
    logic          div_wr;
    logic          div_keep_max;
    logic [NP-1:0] pin_out;

    pin_deglitch_bank #(.NUM_PINS(NP), .DIV_W(DW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_raw      (pin_raw),
        .filt_en      (filt_en),
        .slow_sel     (slow_sel),
        .div_val      (div_val),
        .div_wr       (div_wr),
        .div_keep_max (div_keep_max),
        .pin_out      (pin_out)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct {
        int unsigned due;
        int          pin;
        logic        val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic judge(string tag, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic expect_pin(int delta, int pin, logic v, string tag);
        exp_t e;
        int   k;
        e.due = cyc + delta;
        e.pin = pin;
        e.val = v;
        e.tag = tag;
        k = 0;
        while (k < sb.size() && sb[k].due <= e.due) k++;
        sb.insert(k, e);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: compares scoreboard items 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.due < cyc) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL %s: sample missed, got none expected %b", e.tag, e.val);
                end else begin
                    judge(e.tag, pin_out[e.pin], e.val);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_div(logic [DW-1:0] v, logic keep);
        div_val      = v;
        div_keep_max = keep;
        div_wr       = 1'b1;
        @(negedge clk);
        div_wr       = 1'b0;
    endtask

    initial begin
        // pins 0,1 filtered; pin 1 slow; pins 2,3 bypassed
        pin_raw      = '1;
        filt_en      = 32'h0000_0003;
        slow_sel     = 32'h0000_0002;
        div_val      = '0;
        div_wr       = 1'b0;
        div_keep_max = 1'b0;
        wait_neg(3);
        judge("R1 filtered pin0 in reset", pin_out[0], 1'b0);
        judge("R1 filtered pin1 in reset", pin_out[1], 1'b0);
        judge("R2 bypass pin2 in reset", pin_out[2], 1'b1);
        rst_n = 1'b1;
        expect_pin(1, 2, 1'b1, "R2 bypass after reset");
        expect_pin(1, 0, 1'b0, "R3 first edge only");
        expect_pin(2, 0, 1'b1, "R3 second edge");
        expect_pin(3, 1, 1'b0, "R1 ticks from zero count, before second tick");
        expect_pin(4, 1, 1'b1, "R1 R4 second tick at edge 4");
        wait_neg(6);

        // one-cycle low pulse on a fast pin and a bypass pin
        pin_raw[0] = 1'b0;
        pin_raw[2] = 1'b0;
        expect_pin(1, 2, 1'b0, "R2 bypass follows low");
        expect_pin(2, 2, 1'b1, "R2 bypass follows high");
        expect_pin(1, 0, 1'b1, "R3 pulse ignored a");
        expect_pin(2, 0, 1'b1, "R3 pulse ignored b");
        expect_pin(3, 0, 1'b1, "R3 pulse ignored c");
        wait_neg(1);
        pin_raw[0] = 1'b1;
        pin_raw[2] = 1'b1;
        wait_neg(2);
        pin_raw[0] = 1'b0;
        expect_pin(1, 0, 1'b1, "R3 held low first edge");
        expect_pin(2, 0, 1'b0, "R3 held low second edge");
        wait_neg(4);

        // slow pin with N = 3 (period 8)
        wr_div(24'd3, 1'b0);
        pin_raw[1] = 1'b0;
        expect_pin(15, 1, 1'b1, "R4 before second tick");
        expect_pin(16, 1, 1'b0, "R4 R5 second tick");
        wait_neg(23);
        pin_raw[1] = 1'b1;  // present only at one tick edge
        wait_neg(1);
        pin_raw[1] = 1'b0;
        expect_pin(9, 1, 1'b0, "R5 single-tick level ignored");
        wait_neg(15);
        pin_raw[1] = 1'b1;
        expect_pin(8, 1, 1'b0, "R5 held across one tick");
        expect_pin(9, 1, 1'b1, "R5 held across two ticks");
        wait_neg(12);

        // restart mid-period with the same value
        wr_div(24'd3, 1'b0);
        pin_raw[1] = 1'b0;
        expect_pin(15, 1, 1'b1, "R8 restart delays tick");
        expect_pin(16, 1, 1'b0, "R8 restart period");
        wait_neg(23);

        // write exactly on a tick edge together with a new level
        pin_raw[1] = 1'b1;
        wr_div(24'd3, 1'b0);
        expect_pin(7, 1, 1'b0, "R8 collision before next tick");
        expect_pin(8, 1, 1'b1, "R8 collision tick kept");
        wait_neg(11);

        // keep-max with a smaller request
        wr_div(24'd1, 1'b1);
        pin_raw[1] = 1'b0;
        expect_pin(15, 1, 1'b1, "R7 smaller request ignored a");
        expect_pin(16, 1, 1'b0, "R7 smaller request ignored b");
        wait_neg(19);

        // keep-max with a larger request
        wr_div(24'd5, 1'b1);
        pin_raw[1] = 1'b1;
        expect_pin(23, 1, 1'b0, "R7 larger request a");
        expect_pin(24, 1, 1'b1, "R7 larger request b");
        wait_neg(29);

        // plain load of a smaller value
        wr_div(24'd1, 1'b0);
        pin_raw[1] = 1'b0;
        expect_pin(7, 1, 1'b1, "R6 load smaller a");
        expect_pin(8, 1, 1'b0, "R6 load smaller b");
        wait_neg(10);

        // pin 3 has been bypassed with raw high; enable while dropping raw
        filt_en[3] = 1'b1;
        pin_raw[3] = 1'b0;
        expect_pin(1, 3, 1'b1, "R9 tracked level shown");
        expect_pin(2, 3, 1'b0, "R9 new level after two edges");

        wait (sb.size() == 0);
        wait_neg(2);
        summary();
        $finish;
    end

endmodule